// File: doc/BRIEF.md
# Internal/External Memory Access Router

This block takes byte-addressed read and write requests from a 32-bit processor memory port and sends each one to one of two places: a 2 KB on-chip static RAM, or an external memory bus. The address space is treated as signed and linear. The on-chip RAM window sits at the most negative end, 0x80000000 to 0x800007FF. Every other address, from 0x80000800 up through 0x00000000 to 0x7FFFFFFF, belongs to external memory.

An internal access finishes in the cycle the request is presented. An external access is registered onto the external bus, which is held steady until that bus signals ready; that ready is then passed back to the processor. The router also handles the byte side of the traffic:

- It produces little-endian byte-lane enables.
- It places write bytes onto the correct lanes.
- For byte reads, it extracts the addressed byte and returns it zero-extended.
- It rejects word accesses that are not word-aligned.

A strap input turns the internal RAM off. The strap is sampled while reset is asserted, and the last value seen before reset deasserts is held. When that held value is high, the internal window is routed to the external bus.

Top module: `mem_router`

## Requirements
- R1: With the held strap low, an address whose bits 31:11 equal 0x100000 (0x80000000 to 0x800007FF) goes to internal RAM, and every other address goes to the external bus.
- R2: An aligned internal access raises cpu_ready in the same cycle the request is presented. A write is visible to every later read of the same bytes.
- R3: An external access drives ext_req starting in the cycle after acceptance. ext_addr, ext_we, ext_be and ext_wdata hold steady until ext_ready is high. While waiting, cpu_ready stays low. In the cycle ext_ready is high, cpu_ready is high and cpu_rdata carries the returned data.
- R4: Only one external access is outstanding at a time. While one is waiting, no new access is accepted. ext_req falls in the cycle after the cycle in which ext_ready was seen.
- R5: When the strap held at reset deassertion is high, addresses in the internal window go to the external bus.
- R6: Changes on the strap after reset has deasserted have no effect on routing.
- R7: Byte-lane enables follow the access size and address:
  - cpu_word = 0 selects a byte access, which drives ext_be = 1 << addr[1:0].
  - cpu_word = 1 selects a word access, which drives ext_be = 4'b1111.
- R8: Data is little-endian: the byte at address offset k occupies data bits 8k+7:8k.
  - A byte write takes its data from cpu_wdata[7:0], and the external bus sees that byte copied onto all four lanes.
  - A byte read returns the addressed byte zero-extended in cpu_rdata[7:0].
- R9: A word access with addr[1:0] not equal to zero raises cpu_misalign and cpu_ready together in the cycle it is presented. It writes nothing and issues nothing externally.
- R10: While reset is asserted, and in the first cycle after it deasserts, ext_req is low, and cpu_ready is low when no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_ram_off_strap | input | 1 | Internal RAM disable strap, held at reset release |
| cpu_req | input | 1 | Request valid, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_word | input | 1 | 1 = word access, 0 = byte access |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data (byte writes use bits 7:0) |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | Access complete |
| cpu_misalign | output | 1 | Misaligned word access rejected |
| ext_req | output | 1 | External access pending |
| ext_we | output | 1 | External write |
| ext_addr | output | 32 | External byte address |
| ext_be | output | 4 | External byte-lane enables |
| ext_wdata | output | 32 | External write data on lanes |
| ext_rdata | input | 32 | External read word |
| ext_ready | input | 1 | External access complete |

## Verification
Three kinds of internal fault show up at the ports quickly:

- **Wrong address decode or wrong held strap.** An access lands on the other target. This appears as a change in the external transaction count, or as a wrong external address on the very access that was misrouted.
- **Faulty lane logic.** A wrong ext_be value, or corrupted byte data, appears on the first byte access to the affected lane.
- **Faulty wait logic.** cpu_ready arrives at the wrong cycle, or ext_req fails to drop. The exact-cycle count of each external access with fixed latency exposes this on the first such access.

The bench sweeps every internal word, and every byte lane of a region, against its own memory model.

// File: rtl/mem_router_pkg.sv
package mem_router_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int LANES      = DATA_W / 8;
    localparam int LANE_IDX_W = $clog2(LANES);

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } acc_size_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_INT  = 2'd1,
        TGT_EXT  = 2'd2,
        TGT_ERR  = 2'd3
    } target_e;

    typedef enum logic {
        ST_IDLE     = 1'b0,
        ST_EXT_WAIT = 1'b1
    } rt_state_e;

    typedef struct packed {
        logic              we;
        acc_size_e         size;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } mem_req_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              we;
        acc_size_e         size;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wdata;
    } ext_cmd_t;

    function automatic logic [LANES-1:0] lane_enables(acc_size_e sz, logic [LANE_IDX_W-1:0] off);
        logic [LANES-1:0] one;
        one = {{(LANES-1){1'b0}}, 1'b1};
        if (sz == SZ_WORD) return {LANES{1'b1}};
        return one << off;
    endfunction

    function automatic logic [DATA_W-1:0] place_wdata(acc_size_e sz, logic [DATA_W-1:0] wd);
        if (sz == SZ_WORD) return wd;
        return {LANES{wd[7:0]}};
    endfunction

    function automatic logic [DATA_W-1:0] steer_rdata(acc_size_e sz, logic [LANE_IDX_W-1:0] off,
                                                      logic [DATA_W-1:0] w);
        if (sz == SZ_WORD) return w;
        return {{(DATA_W-8){1'b0}}, w[8*off +: 8]};
    endfunction

endpackage

// File: rtl/mr_strap_latch.sv
module mr_strap_latch (
    input  logic clk,
    input  logic rst,
    input  logic strap_in,
    output logic int_off
);
    always_ff @(posedge clk) begin
        if (rst) int_off <= strap_in;
    end

    // R6: held value never changes outside reset
    a_r6_strap_held: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(int_off));
endmodule

// File: rtl/mr_addr_decode.sv
module mr_addr_decode
    import mem_router_pkg::*;
#(
    parameter logic [ADDR_W-1:0] INT_BASE  = 32'h8000_0000,
    parameter int                INT_BYTES = 2048
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     valid,
    input  mem_req_t req,
    input  logic     int_off,
    output target_e  target
);
    localparam int INT_AW = $clog2(INT_BYTES);

    logic in_window;
    logic misaligned;

    assign in_window  = (req.addr[ADDR_W-1:INT_AW] == INT_BASE[ADDR_W-1:INT_AW]);
    assign misaligned = (req.size == SZ_WORD) && (req.addr[LANE_IDX_W-1:0] != '0);

    always_comb begin
        if (!valid)                     target = TGT_NONE;
        else if (misaligned)            target = TGT_ERR;
        else if (in_window && !int_off) target = TGT_INT;
        else                            target = TGT_EXT;
    end

    // R5: with the strap held high nothing is decoded as internal
    a_r5_strap_remaps: assert property (@(posedge clk) disable iff (rst)
        int_off |-> target != TGT_INT);
endmodule

// File: rtl/mr_int_sram.sv
module mr_int_sram
    import mem_router_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] idx,
    input  logic [LANES-1:0]         be,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && be[k]) lane_mem[idx] <= wdata[8*k +: 8];
        end

        assign rdata[8*k +: 8] = lane_mem[idx];
    end
endmodule

// File: rtl/mr_ext_port.sv
module mr_ext_port
    import mem_router_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     launch,
    input  ext_cmd_t cmd_in,
    input  logic     ext_ready,
    output logic     busy,
    output ext_cmd_t cmd_q
);
    rt_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cmd_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (launch) begin
                    state <= ST_EXT_WAIT;
                    cmd_q <= cmd_in;
                end
                ST_EXT_WAIT: if (ext_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state == ST_EXT_WAIT);

    // R3: command held steady while waiting
    a_r3_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        busy && !ext_ready |=> busy && $stable(cmd_q));
    // R4: request released right after completion
    a_r4_release: assert property (@(posedge clk) disable iff (rst)
        busy && ext_ready |=> !busy);
    // R10: idle after reset
    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> !busy);
endmodule

// File: rtl/mem_router.sv
module mem_router
    import mem_router_pkg::*;
#(
    parameter logic [ADDR_W-1:0] INT_BASE  = 32'h8000_0000,
    parameter int                INT_BYTES = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              int_ram_off_strap,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_word,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              cpu_misalign,
    output logic              ext_req,
    output logic              ext_we,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [LANES-1:0]  ext_be,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic [DATA_W-1:0] ext_rdata,
    input  logic              ext_ready
);
    localparam int INT_AW = $clog2(INT_BYTES);
    localparam int DEPTH  = INT_BYTES / LANES;
    localparam int IDX_W  = $clog2(DEPTH);

    mem_req_t  req;
    target_e   target;
    ext_cmd_t  cmd_new, cmd_q;
    logic      int_off, busy;
    logic      int_go, ext_go, err_go;
    logic [LANES-1:0]  be;
    logic [DATA_W-1:0] lanes_w, sram_rdata;
    logic [IDX_W-1:0]  idx;

    assign req = '{we: cpu_we, size: acc_size_e'(cpu_word), addr: cpu_addr, wdata: cpu_wdata};

    mr_strap_latch u_strap (
        .clk(clk), .rst(rst), .strap_in(int_ram_off_strap), .int_off(int_off)
    );

    mr_addr_decode #(.INT_BASE(INT_BASE), .INT_BYTES(INT_BYTES)) u_dec (
        .clk(clk), .rst(rst), .valid(cpu_req), .req(req), .int_off(int_off), .target(target)
    );

    assign int_go  = !busy && (target == TGT_INT);
    assign ext_go  = !busy && (target == TGT_EXT);
    assign err_go  = !busy && (target == TGT_ERR);
    assign be      = lane_enables(req.size, req.addr[LANE_IDX_W-1:0]);
    assign lanes_w = place_wdata(req.size, req.wdata);
    assign idx     = req.addr[INT_AW-1:LANE_IDX_W];

    mr_int_sram #(.DEPTH(DEPTH)) u_sram (
        .clk(clk), .wr_en(int_go && req.we), .idx(idx), .be(be),
        .wdata(lanes_w), .rdata(sram_rdata)
    );

    assign cmd_new = '{addr: req.addr, we: req.we, size: req.size, be: be, wdata: lanes_w};

    mr_ext_port u_ext (
        .clk(clk), .rst(rst), .launch(ext_go), .cmd_in(cmd_new),
        .ext_ready(ext_ready), .busy(busy), .cmd_q(cmd_q)
    );

    assign ext_req   = busy;
    assign ext_we    = cmd_q.we;
    assign ext_addr  = cmd_q.addr;
    assign ext_be    = cmd_q.be;
    assign ext_wdata = cmd_q.wdata;

    assign cpu_ready    = int_go || err_go || (busy && ext_ready);
    assign cpu_misalign = err_go;

    always_comb begin
        cpu_rdata = '0;
        if (int_go && !req.we)
            cpu_rdata = steer_rdata(req.size, req.addr[LANE_IDX_W-1:0], sram_rdata);
        else if (busy && ext_ready && !cmd_q.we)
            cpu_rdata = steer_rdata(cmd_q.size, cmd_q.addr[LANE_IDX_W-1:0], ext_rdata);
    end

    // R2: aligned internal access completes in its first cycle
    a_r2_int_one_cycle: assert property (@(posedge clk) disable iff (rst)
        cpu_req && !ext_req && !int_off && !cpu_misalign &&
        cpu_addr[ADDR_W-1:INT_AW] == INT_BASE[ADDR_W-1:INT_AW] |-> cpu_ready);
    // R3: processor waits while external access is pending
    a_r3_wait_low: assert property (@(posedge clk) disable iff (rst)
        ext_req && !ext_ready |-> !cpu_ready);
    // R7: lane enables are one-hot or full
    a_r7_lane_shape: assert property (@(posedge clk) disable iff (rst)
        ext_req |-> (ext_be == {LANES{1'b1}}) || ($countones(ext_be) == 1));
    // R9: rejected access issues nothing
    a_r9_no_issue: assert property (@(posedge clk) disable iff (rst)
        cpu_misalign |=> !ext_req);
    // R9: misalign only reported together with completion
    a_r9_with_ready: assert property (@(posedge clk) disable iff (rst)
        cpu_misalign |-> cpu_ready);
endmodule

// File: tb/test_mem_router.sv
module test_mem_router;
    localparam time PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_pin = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_word = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready, cpu_misalign;
    logic        ext_req, ext_we;
    logic [31:0] ext_addr, ext_wdata;
    logic [3:0]  ext_be;
    logic [31:0] ext_rdata = '0;
    logic        ext_ready = 1'b0;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    int          ext_lat = 0;
    int          wcnt = 0;
    int          ext_count = 0;
    logic [31:0] last_addr, last_wdata;
    logic [3:0]  last_be;
    logic        last_we;
    logic [31:0] exp_mem [512];

    always #(PERIOD/2) clk = ~clk;

    mem_router i_mem_router (
        .clk(clk), .rst(rst), .int_ram_off_strap(strap_pin),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_word(cpu_word),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .cpu_misalign(cpu_misalign),
        .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr), .ext_be(ext_be),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_ready(ext_ready)
    );

    function automatic logic [31:0] ext_pat(logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'h5A3C_96F1;
    endfunction

    function automatic logic [31:0] int_pat(int i);
        return (i * 32'h9E37_79B1) ^ 32'h0F0F_1234;
    endfunction

    // external memory model: fixed latency, responds at negedges
    always @(negedge clk) begin
        ext_ready = 1'b0;
        if (ext_req) begin
            ext_rdata = ext_pat(ext_addr);
            if (wcnt >= ext_lat) begin
                ext_ready  = 1'b1;
                last_addr  = ext_addr;
                last_wdata = ext_wdata;
                last_be    = ext_be;
                last_we    = ext_we;
                ext_count++;
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic word, input logic [31:0] addr,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output int cyc, output logic mis);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_word = word; cpu_addr = addr; cpu_wdata = wd;
        cyc = 0;
        forever begin
            #1;
            cyc++;
            if (cpu_ready || cyc > 40) break;
            @(negedge clk);
        end
        rd  = cpu_rdata;
        mis = cpu_misalign;
        @(posedge clk);
        #1 cpu_req = 1'b0;
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst = 1'b1; strap_pin = strap; cpu_req = 1'b0;
        #1;
        check("R10 ext_req in reset", {31'b0, ext_req}, 32'd0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10 ext_req after reset", {31'b0, ext_req}, 32'd0);
        check("R10 ready idle", {31'b0, cpu_ready}, 32'd0);
        @(negedge clk);
        strap_pin = ~strap;
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int          cyc;
        logic        mis;
        int          cnt0;
        logic [31:0] addrs [6];

        do_reset(1'b0);   // strap now toggled high after reset (R6)

        // R1 R2 R6: full internal word sweep
        for (int i = 0; i < 512; i++) begin
            exp_mem[i] = int_pat(i);
            access(1'b1, 1'b1, 32'h8000_0000 + 32'(4*i), exp_mem[i], rd, cyc, mis);
            if (i == 0 || i == 511) check("R2 int write cycles", cyc, 1);
        end
        cnt0 = ext_count;
        for (int i = 0; i < 512; i++) begin
            access(1'b0, 1'b1, 32'h8000_0000 + 32'(4*i), 32'h0, rd, cyc, mis);
            check("R1 R2 R6 int word readback", rd, exp_mem[i]);
            if (i == 0 || i == 511) check("R2 int read cycles", cyc, 1);
        end
        check("R1 R6 no ext traffic for int window", ext_count, cnt0);

        // R8: byte writes across lanes, then byte and word reads
        for (int i = 0; i < 8; i++) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] b;
                b = 8'((i * 4 + k) * 7 + 3);
                access(1'b1, 1'b0, 32'h8000_0100 + 32'(4*i + k), {24'hDEADBE, b}, rd, cyc, mis);
                exp_mem[64 + i][8*k +: 8] = b;
            end
        end
        for (int i = 0; i < 8; i++) begin
            for (int k = 0; k < 4; k++) begin
                access(1'b0, 1'b0, 32'h8000_0100 + 32'(4*i + k), 32'h0, rd, cyc, mis);
                check("R8 int byte read", rd, {24'h0, exp_mem[64 + i][8*k +: 8]});
            end
            access(1'b0, 1'b1, 32'h8000_0100 + 32'(4*i), 32'h0, rd, cyc, mis);
            check("R8 int word after byte writes", rd, exp_mem[64 + i]);
        end

        // R9: misaligned word accesses
        for (int off = 1; off < 4; off++) begin
            cnt0 = ext_count;
            access(1'b1, 1'b1, 32'h8000_0000 + 32'(off), 32'hFFFF_FFFF, rd, cyc, mis);
            check("R9 misalign flag", {31'b0, mis}, 32'd1);
            check("R9 misalign cycles", cyc, 1);
            access(1'b1, 1'b1, 32'h0000_1000 + 32'(off), 32'hFFFF_FFFF, rd, cyc, mis);
            check("R9 ext misalign flag", {31'b0, mis}, 32'd1);
            @(negedge clk);
            check("R9 no ext issue", ext_count, cnt0);
        end
        access(1'b0, 1'b1, 32'h8000_0000, 32'h0, rd, cyc, mis);
        check("R9 int word untouched", rd, exp_mem[0]);
        check("R9 aligned no flag", {31'b0, mis}, 32'd0);

        // R1 R3 R4 R7 R8: external boundary addresses across latencies
        addrs[0] = 32'h8000_0800; addrs[1] = 32'hFFFF_FFFC; addrs[2] = 32'h0000_0000;
        addrs[3] = 32'h7FFF_FFFC; addrs[4] = 32'h1234_5678; addrs[5] = 32'h7FFF_FF6C;
        for (int a = 0; a < 6; a++) begin
            for (int lat = 0; lat < 4; lat++) begin
                logic [31:0] wa;
                wa = {addrs[a][31:2], 2'b00};
                ext_lat = lat;
                cnt0 = ext_count;
                access(1'b1, 1'b1, wa, int_pat(a * 4 + lat), rd, cyc, mis);
                check("R1 ext routed", ext_count, cnt0 + 1);
                check("R3 ext cycles", cyc, lat + 2);
                check("R3 ext addr", last_addr, wa);
                check("R7 word be", {28'b0, last_be}, 32'hF);
                check("R3 ext wdata", last_wdata, int_pat(a * 4 + lat));
                check("R3 ext we", {31'b0, last_we}, 32'd1);
                access(1'b0, 1'b1, wa, 32'h0, rd, cyc, mis);
                check("R3 ext read data", rd, ext_pat(wa));
                check("R4 ext read cycles", cyc, lat + 2);
                for (int k = 0; k < 4; k++) begin
                    access(1'b0, 1'b0, wa + 32'(k), 32'h0, rd, cyc, mis);
                    check("R7 byte be", {28'b0, last_be}, 32'(1 << k));
                    check("R8 ext byte read", rd, (ext_pat(wa) >> (8 * k)) & 32'hFF);
                    access(1'b1, 1'b0, wa + 32'(k), 32'h0000_00A0 + 32'(k), rd, cyc, mis);
                    check("R8 ext byte lanes", last_wdata, {4{8'hA0 + 8'(k)}});
                end
            end
        end
        ext_lat = 1;

        // R5 R6: strap held high remaps internal window
        do_reset(1'b1);   // strap driven low afterwards
        cnt0 = ext_count;
        access(1'b1, 1'b1, 32'h8000_0010, 32'hCAFE_F00D, rd, cyc, mis);
        check("R5 remapped to ext", ext_count, cnt0 + 1);
        check("R5 ext addr", last_addr, 32'h8000_0010);
        check("R5 ext cycles", cyc, 3);
        access(1'b0, 1'b1, 32'h8000_07FC, 32'h0, rd, cyc, mis);
        check("R6 strap change ignored", ext_count, cnt0 + 2);
        check("R5 ext read", rd, ext_pat(32'h8000_07FC));

        // back to internal; RAM contents kept across reset
        do_reset(1'b0);
        cnt0 = ext_count;
        access(1'b0, 1'b1, 32'h8000_07FC, 32'h0, rd, cyc, mis);
        check("R1 R6 int after re-reset", rd, exp_mem[511]);
        check("R6 no ext traffic", ext_count, cnt0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule